// File: doc/BRIEF.md
# Read-Data Strobe Pulse Generator

This block qualifies each decoded bit of a two-frequency card-stripe decoder for a host. A one-cycle bit-ready event carries a new bit value. The block then waits a fixed settling delay and drives an active-low read strobe for a width that a digital setting selects. The host samples the data on or after the falling edge of the strobe. The bit is presented in both true and inverted form.

The data register loads at the bit-ready event itself. That point lies inside the settling delay, so the data is stable well before the strobe falls. The data then holds until the next event, and that event comes at least one settling delay ahead of the next falling edge.

If bit events arrive faster than delay plus width, the running pulse is cut off at the next event. A new delay-then-pulse cycle starts from that event. All times are counted in system-clock ticks through a ticks-per-microsecond parameter.

Top module: `f2f_read_strobe`

## Requirements
- R1: During synchronous reset and after it with no event, `rd_strobe_n` is 1, `rd_data` is 0 and `rd_data_n` is 1.
- R2: The first cycle with `rd_strobe_n` low follows the clock edge that lies DELAY_US*TICKS_PER_US edges after the edge that sampled `bit_rdy` high.
- R3: Without an interrupting event, `rd_strobe_n` stays low for exactly clamp(`width_us`)*TICKS_PER_US cycles, where `width_us` is sampled with the event.
- R4: The clamp maps a `width_us` below MIN_US to MIN_US and one above MAX_US to MAX_US, and leaves other values unchanged.
- R5: A `bit_rdy` sampled while `rd_strobe_n` is low returns it high in the next cycle. A full delay-then-pulse cycle for the new bit starts from that edge.
- R6: A `bit_rdy` sampled during the delay restarts the delay. The superseded bit receives no strobe.
- R7: `rd_data` takes `bit_val` at the edge that samples `bit_rdy`, and `rd_data_n` is always its complement.
- R8: The data outputs change only at edges that sample `bit_rdy`. They therefore stay constant across every low strobe and until at least DELAY_US before the next falling edge.
- R9: Every event that is neither cut nor restarted yields exactly one low pulse. Without events, no further pulse appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_rdy | input | 1 | One-cycle pulse: a decoded bit is ready |
| bit_val | input | 1 | Value of the decoded bit, valid with bit_rdy |
| width_us | input | SET_W | Requested strobe width in microseconds |
| rd_strobe_n | output | 1 | Active-low read strobe |
| rd_data | output | 1 | Decoded bit, true form |
| rd_data_n | output | 1 | Decoded bit, inverted form |

## Verification
A wrong phase or count in the timing sequencer shows at the strobe pin. The falling edge arrives off the delay by one or more cycles, or the low time disagrees with the clamped width by the time the pulse ends. Both appear within one delay-plus-width window of the event. A stale width register shows only on the pulse after a width change, which is why the widths alternate below, inside and above the legal range. A data register that moves outside an event shows on the very next cycle as a data change while the strobe is low, or as a mismatch against the bit last delivered.

// File: rtl/f2f_strobe_pkg.sv
package f2f_strobe_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_LOW  = 2'd2
    } strobe_phase_e;

    typedef struct packed {
        logic fire;
        logic value;
    } bit_evt_t;

    function automatic int unsigned clamp_us(input int unsigned v,
                                             input int unsigned lo,
                                             input int unsigned hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/f2f_width_sel.sv
module f2f_width_sel
    import f2f_strobe_pkg::*;
#(
    parameter int unsigned TICKS_PER_US = 250,
    parameter int unsigned MIN_US       = 14,
    parameter int unsigned MAX_US       = 60,
    parameter int unsigned SET_W        = 6,
    parameter int unsigned CNT_W        = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [SET_W-1:0] set_us,
    output logic [CNT_W-1:0] width_ticks
);
    localparam int unsigned MIN_T = MIN_US * TICKS_PER_US;
    localparam int unsigned MAX_T = MAX_US * TICKS_PER_US;

    logic [CNT_W-1:0] next_ticks;

    always_comb begin
        next_ticks = CNT_W'(clamp_us(32'(set_us), MIN_US, MAX_US) * TICKS_PER_US);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            width_ticks <= CNT_W'(MIN_T);
        end else if (load) begin
            width_ticks <= next_ticks;
        end
    end

    p_width_range_r4: assert property (@(posedge clk) disable iff (rst)
        (32'(width_ticks) >= MIN_T) && (32'(width_ticks) <= MAX_T));

endmodule

// File: rtl/f2f_data_hold.sv
module f2f_data_hold
    import f2f_strobe_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bit_evt_t evt,
    output logic     data_q,
    output logic     data_nq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= 1'b0;
            data_nq <= 1'b1;
        end else if (evt.fire) begin
            data_q  <= evt.value;
            data_nq <= ~evt.value;
        end
    end

    p_compl_r7: assert property (@(posedge clk) disable iff (rst)
        data_q != data_nq);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !evt.fire |=> $stable(data_q));

endmodule

// File: rtl/f2f_strobe_fsm.sv
module f2f_strobe_fsm
    import f2f_strobe_pkg::*;
#(
    parameter int unsigned DELAY_T = 3000,
    parameter int unsigned CNT_W   = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  logic [CNT_W-1:0] width_ticks,
    output logic             strobe_n
);
    localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DELAY_T - 1);

    strobe_phase_e    phase;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (evt) begin
            phase <= PH_WAIT;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_WAIT: begin
                    if (cnt == DLY_LAST) begin
                        phase <= PH_LOW;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_LOW: begin
                    if (cnt == width_ticks - 1'b1) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign strobe_n = (phase != PH_LOW);

    p_reset_high_r1: assert property (@(posedge clk)
        rst |=> strobe_n);

    p_delay_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT) |-> (32'(cnt) < DELAY_T));

    p_width_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOW) |-> (cnt < width_ticks));

    p_cut_short_r5: assert property (@(posedge clk) disable iff (rst)
        (!strobe_n && evt) |=> strobe_n);

    p_restart_r6: assert property (@(posedge clk) disable iff (rst)
        evt |=> (phase == PH_WAIT && cnt == '0));

endmodule

// File: rtl/f2f_read_strobe.sv
module f2f_read_strobe
    import f2f_strobe_pkg::*;
#(
    parameter int unsigned TICKS_PER_US = 250,
    parameter int unsigned DELAY_US     = 12,
    parameter int unsigned MIN_US       = 14,
    parameter int unsigned MAX_US       = 60,
    parameter int unsigned SET_W        = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_rdy,
    input  logic             bit_val,
    input  logic [SET_W-1:0] width_us,
    output logic             rd_strobe_n,
    output logic             rd_data,
    output logic             rd_data_n
);
    localparam int unsigned DELAY_T = DELAY_US * TICKS_PER_US;
    localparam int unsigned TOP_T   = max_u(MAX_US, DELAY_US) * TICKS_PER_US;
    localparam int unsigned CNT_W   = $clog2(TOP_T + 1);

    bit_evt_t         evt;
    logic [CNT_W-1:0] width_ticks;

    always_comb begin
        evt.fire  = bit_rdy;
        evt.value = bit_val;
    end

    f2f_width_sel #(
        .TICKS_PER_US(TICKS_PER_US),
        .MIN_US      (MIN_US),
        .MAX_US      (MAX_US),
        .SET_W       (SET_W),
        .CNT_W       (CNT_W)
    ) u_width (
        .clk        (clk),
        .rst        (rst),
        .load       (evt.fire),
        .set_us     (width_us),
        .width_ticks(width_ticks)
    );

    f2f_data_hold u_data (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .data_q (rd_data),
        .data_nq(rd_data_n)
    );

    f2f_strobe_fsm #(
        .DELAY_T(DELAY_T),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt.fire),
        .width_ticks(width_ticks),
        .strobe_n   (rd_strobe_n)
    );

endmodule

// File: tb/f2f_read_strobe_test.sv
module f2f_read_strobe_test;
    localparam int TPU   = 4;
    localparam int DLY_U = 12;
    localparam int MIN_U = 14;
    localparam int MAX_U = 60;
    localparam int D     = DLY_U * TPU;
    localparam int BIG   = 1000000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_rdy = 1'b0;
    logic       bit_val = 1'b0;
    logic [5:0] width_us = 6'd20;
    logic       rd_strobe_n, rd_data, rd_data_n;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    f2f_read_strobe #(
        .TICKS_PER_US(TPU), .DELAY_US(DLY_U), .MIN_US(MIN_U), .MAX_US(MAX_U), .SET_W(6)
    ) uut (
        .clk(clk), .rst(rst), .bit_rdy(bit_rdy), .bit_val(bit_val), .width_us(width_us),
        .rd_strobe_n(rd_strobe_n), .rd_data(rd_data), .rd_data_n(rd_data_n)
    );

    always #2 clk = ~clk;

    function automatic int clamp_w(input int v);
        if (v < MIN_U) return MIN_U * TPU;
        if (v > MAX_U) return MAX_U * TPU;
        return v * TPU;
    endfunction

    // behavioural model: age since last accepted event
    int   m_age = BIG;
    int   m_w = MIN_U * TPU;
    logic m_data = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_age  = BIG;
            m_data = 1'b0;
        end else if (bit_rdy) begin
            m_age  = 0;
            m_w    = clamp_w(int'(width_us));
            m_data = bit_val;
        end else if (m_age < BIG) begin
            m_age = m_age + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model (R1 R2 R3 R5 R6 R7 R9)
    always @(negedge clk) begin
        if (!rst) begin
            logic exp_n;
            exp_n = !(m_age >= D && m_age < D + m_w);
            check(rd_strobe_n == exp_n, "R2/R3/R5/R6/R9 strobe vs model",
                  int'(rd_strobe_n), int'(exp_n));
            check(rd_data == m_data && rd_data_n == ~m_data, "R7 data vs model",
                  int'({rd_data, rd_data_n}), int'({m_data, ~m_data}));
        end
    end

    // R8: data must not move while the strobe is low unless an event cut it
    logic prev_data = 1'b0;
    logic prev_low = 1'b0;
    always @(negedge clk) begin
        if (!rst && prev_low && !rd_strobe_n)
            check(rd_data == prev_data, "R8 data stable while strobe low",
                  int'(rd_data), int'(prev_data));
        prev_data = rd_data;
        prev_low  = !rd_strobe_n;
    end

    task automatic fire(input logic v, input int w);
        @(negedge clk);
        bit_rdy  = 1'b1;
        bit_val  = v;
        width_us = 6'(w);
        @(negedge clk);
        bit_rdy = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // single event, measure delay and width at the ports
    task automatic single(input logic v, input int w, input string wreq);
        int ev, fall, guard;
        fire(v, w);
        ev = cyc;
        guard = 0;
        while (rd_strobe_n && guard < 1000) begin @(negedge clk); guard++; end
        fall = cyc;
        check(fall - ev == D, "R2 delay to falling edge", fall - ev, D);
        check(rd_data == v && rd_data_n == ~v, "R7 data at falling edge",
              int'(rd_data), int'(v));
        guard = 0;
        while (!rd_strobe_n && guard < 1000) begin @(negedge clk); guard++; end
        check(cyc - fall == clamp_w(w), wreq, cyc - fall, clamp_w(w));
        idle(20);
    endtask

    initial begin
        int t0, lows;
        idle(4);
        check(rd_strobe_n == 1'b1 && rd_data == 1'b0 && rd_data_n == 1'b1,
              "R1 outputs in reset", int'({rd_strobe_n, rd_data, rd_data_n}), 3'b101);
        rst = 1'b0;
        idle(30);
        check(rd_strobe_n == 1'b1 && rd_data == 1'b0 && rd_data_n == 1'b1,
              "R1 idle after reset", int'({rd_strobe_n, rd_data, rd_data_n}), 3'b101);

        single(1'b1, 20, "R3 width 20us");
        single(1'b0, 5,  "R4 width clamped up to minimum");
        single(1'b1, 63, "R4 width clamped down to maximum");
        single(1'b0, 14, "R3 width at minimum");
        single(1'b1, 60, "R3 width at maximum");

        // R5: next bit arrives while the strobe is low
        fire(1'b1, 30);
        idle(D + 10 - 1);
        check(rd_strobe_n == 1'b0, "R5 strobe low before cut", int'(rd_strobe_n), 0);
        fire(1'b0, 14);
        check(rd_strobe_n == 1'b1, "R5 strobe high after cut", int'(rd_strobe_n), 1);
        check(rd_data == 1'b0, "R5 new bit loaded at cut", int'(rd_data), 0);
        idle(D + 14 * TPU + 20);

        // R6: events inside the delay restart it
        fire(1'b1, 20);
        idle(15);
        fire(1'b0, 20);
        idle(15);
        fire(1'b1, 20);
        t0 = cyc;
        lows = 0;
        for (int i = 0; i < D + 20 * TPU + 30; i++) begin
            @(negedge clk);
            if (!rd_strobe_n) lows++;
            if (i == 20) check(rd_strobe_n == 1'b1, "R6 no strobe for superseded bits",
                               int'(rd_strobe_n), 1);
        end
        check(lows == 20 * TPU, "R6 single pulse after restarts", lows, 20 * TPU);

        // R9: back-to-back events longer than the pulse, then silence
        for (int k = 0; k < 3; k++) begin
            fire(k[0], 14);
            idle(D + 14 * TPU + 5);
        end
        lows = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!rd_strobe_n) lows++;
        end
        check(lows == 0, "R9 no pulse without event", lows, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule